// File: doc/BRIEF.md
# OTG B-Device Session Request Sequencer

This block runs the B-device side of session request on a USB On-The-Go link. It watches the bus while a session is up. When the bus has been idle for long enough it raises an early-suspend flag and then a suspend flag. On suspend it asks the PHY to drain VBUS. Once the PHY reports that the session has ended, and the device is allowed to request sessions, it checks that the line stays in SE0 for a set number of milliseconds. It then pulses the D+ pull-up, pulses VBUS through the charge request, and waits for the host to power the bus.

All timing is counted in ticks of a one-millisecond strobe, so every interval is a parameter in milliseconds. There are two outcomes. If VBUS becomes valid in time, the device connects by driving its D+ pull-up and a success flag is set. If VBUS does not become valid before the timeout, a failure flag is set and every PHY request is dropped. The four status flags are sticky and are cleared by writing one to the matching bit of a clear input.

Top module: `otg_srp_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to bus monitoring, all PHY outputs are low and all four flags (`irq_flags` bit 0 early suspend, bit 1 suspend, bit 2 request success, bit 3 request failed) are cleared.
- R2: While monitoring, bit 0 is set once `EARLY_TICKS` ticks have been counted with `line_idle` high throughout. A cycle with `line_idle` low restarts that count.
- R3: While monitoring, bit 1 is set and `dischrg_vbus` is asserted once `SUSP_TICKS` (greater than `EARLY_TICKS`) idle ticks have been counted. `dischrg_vbus` stays high until the request starts.
- R4: A suspended sequencer begins qualification only while both `srp_capable` and `sess_end` are high. If either one drops during qualification, it goes back to suspend.
- R5: Data line pulsing begins only after `SE0_TICKS` ticks of continuous `line_se0` during qualification. A cycle with `line_se0` low restarts the count.
- R6: `dp_pullup_en` is high for `DP_TICKS` ticks and is then released. After that, `chrg_vbus` is high for `VB_TICKS` ticks. The two are never high together, and `chrg_vbus` is never high together with `dischrg_vbus`.
- R7: `vbus_valid` seen during VBUS pulsing, or during the wait that follows it, moves the block to connected. In that state `dp_pullup_en` is high, `chrg_vbus` is low and bit 2 is set.
- R8: If `TMO_TICKS` ticks pass in the wait without `vbus_valid`, bit 3 is set, all three PHY outputs go low and monitoring resumes.
- R9: Each flag stays set until a cycle in which its `flag_clr` bit is high. If the flag's set condition is active in that same cycle, the set wins.
- R10: A connected device stays connected while `b_valid` is high. When `b_valid` falls it releases the pull-up and returns to monitoring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| srp_capable | input | 1 | Device may request sessions |
| line_idle | input | 1 | Bus shows no activity (idle J state) |
| line_se0 | input | 1 | Both data lines low |
| vbus_valid | input | 1 | PHY: VBUS above valid threshold |
| b_valid | input | 1 | PHY: B-peripheral session valid |
| sess_end | input | 1 | PHY: VBUS below session-end level |
| flag_clr | input | 4 | Write-one-to-clear per flag |
| dischrg_vbus | output | 1 | Request to PHY to discharge VBUS |
| chrg_vbus | output | 1 | Request to PHY to charge VBUS |
| dp_pullup_en | output | 1 | D+ pull-up enable |
| irq_flags | output | 4 | Sticky status flags |

## Verification
The bench builds the block with tiny intervals: early suspend at 3 ticks, suspend at 5, SE0 window 2, D+ pulse 3, VBUS pulse 2 and timeout 6. With these values it can sweep every idle-tick count through both suspend thresholds, every position of an SE0 break, all four combinations of the start gates, and every arrival tick of VBUS valid from the first wait tick to one past the timeout. Expected flags and outputs come from comparing each sweep index against those constants.

// File: rtl/otg_srp_pkg.sv
// Shared state encoding and flag bit positions for the session request sequencer.
package otg_srp_pkg;

    typedef enum logic [2:0] {
        ST_MON    = 3'd0,
        ST_SUSP   = 3'd1,
        ST_SE0Q   = 3'd2,
        ST_DPULSE = 3'd3,
        ST_VPULSE = 3'd4,
        ST_WAITV  = 3'd5,
        ST_CONN   = 3'd6
    } srp_state_e;

    localparam int FLAG_W     = 4;
    localparam int FLG_ESUSP  = 0;
    localparam int FLG_SUSP   = 1;
    localparam int FLG_OK     = 2;
    localparam int FLG_FAIL   = 3;

endpackage

// File: rtl/srp_tick_timer.sv
// Millisecond interval counter.
// Counts strobes while enabled, saturates at all ones, and returns to zero on clear.
// Assumes: clear takes priority over a step in the same cycle.
module srp_tick_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // Purpose: advance, hold or clear the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> cnt >= $past(cnt));

    p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) && $past(rst_n) |-> cnt == '0);

endmodule

// File: rtl/srp_irq_flags.sv
// Sticky status flag bank.
// A flag is set by its set pulse and cleared by a one on its clear bit.
// Assumes: set wins when set and clear meet in the same cycle.
module srp_irq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: hold one sticky flag bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end

        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(q[i]) && !$past(clr[i]) |-> q[i]);

        p_flag_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(set[i]) |-> q[i]);
    end

endmodule

// File: rtl/otg_srp_seq.sv
// B-device session request sequencer.
// Flow: monitor idle -> suspend (discharge) -> SE0 qualification -> D+ pulse
// -> VBUS pulse -> wait for VBUS valid -> connected, or time out back to monitor.
// Assumes: ms_tick is a one-cycle strobe; all inputs are synchronous to clk;
// SUSP_TICKS > EARLY_TICKS; every interval is at least one tick.
module otg_srp_seq #(
    parameter int EARLY_TICKS = 3,
    parameter int SUSP_TICKS  = 6,
    parameter int SE0_TICKS   = 2,
    parameter int DP_TICKS    = 7,
    parameter int VB_TICKS    = 20,
    parameter int TMO_TICKS   = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       srp_capable,
    input  logic       line_idle,
    input  logic       line_se0,
    input  logic       vbus_valid,
    input  logic       b_valid,
    input  logic       sess_end,
    input  logic [3:0] flag_clr,
    output logic       dischrg_vbus,
    output logic       chrg_vbus,
    output logic       dp_pullup_en,
    output logic [3:0] irq_flags
);

    import otg_srp_pkg::*;

    localparam int M1   = (SUSP_TICKS > SE0_TICKS) ? SUSP_TICKS : SE0_TICKS;
    localparam int M2   = (DP_TICKS > VB_TICKS) ? DP_TICKS : VB_TICKS;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXT = (M3 > TMO_TICKS) ? M3 : TMO_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    localparam logic [CW-1:0] C_EARLY = CW'(EARLY_TICKS);
    localparam logic [CW-1:0] C_SUSP  = CW'(SUSP_TICKS);
    localparam logic [CW-1:0] C_SE0   = CW'(SE0_TICKS);
    localparam logic [CW-1:0] C_DP    = CW'(DP_TICKS);
    localparam logic [CW-1:0] C_VB    = CW'(VB_TICKS);
    localparam logic [CW-1:0] C_TMO   = CW'(TMO_TICKS);

    srp_state_e          state, nxt;
    logic [CW-1:0]       cnt;
    logic                cnt_clr;
    logic                cnt_step;
    logic [FLAG_W-1:0]   flag_set;

    // Purpose: interval timer shared by all timed states.
    srp_tick_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (cnt_step),
        .cnt   (cnt)
    );

    // Purpose: sticky status flags with write-one-to-clear.
    srp_irq_flags #(.N(FLAG_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .q     (irq_flags)
    );

    // Purpose: register the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_MON;
        end else begin
            state <= nxt;
        end
    end

    // Purpose: next state, timer control and flag set pulses.
    always_comb begin
        nxt      = state;
        cnt_step = ms_tick;
        cnt_clr  = 1'b0;
        flag_set = '0;
        unique case (state)
            ST_MON: begin
                if (!line_idle) begin
                    cnt_clr = 1'b1;
                end else begin
                    if (cnt >= C_EARLY) flag_set[FLG_ESUSP] = 1'b1;
                    if (cnt >= C_SUSP) begin
                        flag_set[FLG_SUSP] = 1'b1;
                        nxt = ST_SUSP;
                    end
                end
            end
            ST_SUSP: begin
                cnt_step = 1'b0;
                if (srp_capable && sess_end) nxt = ST_SE0Q;
            end
            ST_SE0Q: begin
                if (!srp_capable || !sess_end) begin
                    nxt = ST_SUSP;
                end else if (!line_se0) begin
                    cnt_clr = 1'b1;
                end else if (cnt >= C_SE0) begin
                    nxt = ST_DPULSE;
                end
            end
            ST_DPULSE: begin
                if (cnt >= C_DP) nxt = ST_VPULSE;
            end
            ST_VPULSE: begin
                if (vbus_valid) begin
                    flag_set[FLG_OK] = 1'b1;
                    nxt = ST_CONN;
                end else if (cnt >= C_VB) begin
                    nxt = ST_WAITV;
                end
            end
            ST_WAITV: begin
                if (vbus_valid) begin
                    flag_set[FLG_OK] = 1'b1;
                    nxt = ST_CONN;
                end else if (cnt >= C_TMO) begin
                    flag_set[FLG_FAIL] = 1'b1;
                    nxt = ST_MON;
                end
            end
            ST_CONN: begin
                cnt_step = 1'b0;
                if (!b_valid) nxt = ST_MON;
            end
            default: nxt = ST_MON;
        endcase
        if (nxt != state) cnt_clr = 1'b1;
    end

    // Purpose: decode PHY requests from the registered state.
    always_comb begin
        dischrg_vbus = (state == ST_SUSP);
        chrg_vbus    = (state == ST_VPULSE);
        dp_pullup_en = (state == ST_DPULSE) || (state == ST_CONN);
    end

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(chrg_vbus && dp_pullup_en) && !(chrg_vbus && dischrg_vbus));

    p_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DPULSE) && ($past(state) == ST_SE0Q)
        |-> $past(srp_capable && sess_end && line_se0));

    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[FLG_FAIL]) |-> !chrg_vbus && !dp_pullup_en && !dischrg_vbus);

    p_discharge_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dischrg_vbus) |-> irq_flags[FLG_SUSP]);

    p_connect_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONN) && ($past(state) != ST_CONN) |-> irq_flags[FLG_OK]);

endmodule

// File: tb/otg_srp_seq_test.sv
module otg_srp_seq_test;

    localparam int EARLY = 3;
    localparam int SUSP  = 5;
    localparam int SE0   = 2;
    localparam int DP    = 3;
    localparam int VB    = 2;
    localparam int TMO   = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ms_tick, srp_capable, line_idle, line_se0;
    logic       vbus_valid, b_valid, sess_end;
    logic [3:0] flag_clr;
    logic       dischrg_vbus, chrg_vbus, dp_pullup_en;
    logic [3:0] irq_flags;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    otg_srp_seq #(
        .EARLY_TICKS(EARLY), .SUSP_TICKS(SUSP), .SE0_TICKS(SE0),
        .DP_TICKS(DP), .VB_TICKS(VB), .TMO_TICKS(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .srp_capable(srp_capable),
        .line_idle(line_idle), .line_se0(line_se0), .vbus_valid(vbus_valid),
        .b_valid(b_valid), .sess_end(sess_end), .flag_clr(flag_clr),
        .dischrg_vbus(dischrg_vbus), .chrg_vbus(chrg_vbus),
        .dp_pullup_en(dp_pullup_en), .irq_flags(irq_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            clocks(3);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ms_tick = 0; srp_capable = 0; line_idle = 0; line_se0 = 0;
        vbus_valid = 0; b_valid = 0; sess_end = 0; flag_clr = '0;
        clocks(3);
        rst_n = 1'b1;
        clocks(1);
    endtask

    task automatic go_suspend();
        do_reset();
        line_idle = 1'b1;
        tick(SUSP);
        line_idle = 1'b0;
    endtask

    task automatic go_qualify();
        go_suspend();
        srp_capable = 1'b1; sess_end = 1'b1; line_se0 = 1'b1;
        clocks(2);
    endtask

    task automatic go_wait();
        go_qualify();
        tick(SE0);
        line_se0 = 1'b0;
        tick(DP);
        tick(VB);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 flags", irq_flags, 0);
        chk("R1 outputs", {dischrg_vbus, chrg_vbus, dp_pullup_en}, 0);

        // R2/R3: sweep idle tick counts across both thresholds
        for (int k = 0; k <= SUSP + 1; k++) begin
            do_reset();
            line_idle = 1'b1;
            tick(k);
            chk("R2 early flag", irq_flags[0], int'(k >= EARLY));
            chk("R3 suspend flag", irq_flags[1], int'(k >= SUSP));
            chk("R3 discharge", dischrg_vbus, int'(k >= SUSP));
        end

        // R2: activity restarts idle count
        do_reset();
        line_idle = 1'b1; tick(EARLY - 1);
        line_idle = 1'b0; tick(1);
        line_idle = 1'b1; tick(EARLY - 1);
        chk("R2 restart before", irq_flags[0], 0);
        tick(1);
        chk("R2 restart after", irq_flags[0], 1);

        // R9: set wins over clear; clear works once set is gone
        flag_clr = 4'b0001; clocks(1); flag_clr = '0; clocks(1);
        chk("R9 set wins", irq_flags[0], 1);
        line_idle = 1'b0; clocks(1);
        flag_clr = 4'b0001; clocks(1); flag_clr = '0; clocks(1);
        chk("R9 cleared", irq_flags[0], 0);

        // R4: start gating over all combinations
        for (int c = 0; c < 4; c++) begin
            go_suspend();
            srp_capable = c[0]; sess_end = c[1]; line_se0 = 1'b1;
            clocks(2);
            tick(SE0 + 1);
            chk("R4 pulse gated", dp_pullup_en, int'(c == 3));
            chk("R4 discharge held", dischrg_vbus, int'(c != 3));
        end

        // R4: dropping capability during qualification returns to suspend
        go_qualify();
        srp_capable = 1'b0; clocks(2);
        chk("R4 back to suspend", dischrg_vbus, 1);

        // R5: SE0 break at each position restarts the window
        for (int j = 0; j < SE0; j++) begin
            go_qualify();
            tick(j);
            line_se0 = 1'b0; tick(1);
            line_se0 = 1'b1; tick(SE0 - 1);
            chk("R5 not yet", dp_pullup_en, 0);
            tick(1);
            chk("R5 window met", dp_pullup_en, 1);
        end

        // R6: pulse ordering and widths
        go_qualify();
        tick(SE0);
        line_se0 = 1'b0;
        for (int t = 0; t < DP; t++) begin
            chk("R6 dp pulse on", dp_pullup_en, 1);
            chk("R6 no charge in dp", chrg_vbus, 0);
            tick(1);
        end
        chk("R6 pullup released", dp_pullup_en, 0);
        for (int t = 0; t < VB; t++) begin
            chk("R6 charge on", chrg_vbus, 1);
            chk("R6 no discharge", dischrg_vbus, 0);
            tick(1);
        end
        chk("R6 charge off", chrg_vbus, 0);

        // R7: VBUS valid during VBUS pulsing
        go_qualify();
        tick(SE0); line_se0 = 1'b0; tick(DP);
        vbus_valid = 1'b1; b_valid = 1'b1; clocks(2);
        chk("R7 early connect pullup", dp_pullup_en, 1);
        chk("R7 early connect charge", chrg_vbus, 0);
        chk("R7 early success flag", irq_flags[2], 1);

        // R7/R8: sweep VBUS arrival tick across the timeout
        for (int w = 0; w <= TMO + 1; w++) begin
            go_wait();
            tick(w);
            vbus_valid = 1'b1; b_valid = 1'b1; clocks(2);
            if (w < TMO) begin
                chk("R7 connect pullup", dp_pullup_en, 1);
                chk("R7 success flag", irq_flags[2], 1);
                chk("R7 no fail flag", irq_flags[3], 0);
            end else begin
                chk("R8 fail flag", irq_flags[3], 1);
                chk("R8 outputs off", {dischrg_vbus, chrg_vbus, dp_pullup_en}, 0);
                chk("R8 no success", irq_flags[2], 0);
            end
        end

        // R10: stay connected while b_valid high, release on fall
        go_wait();
        vbus_valid = 1'b1; b_valid = 1'b1; clocks(2);
        tick(4);
        chk("R10 held", dp_pullup_en, 1);
        b_valid = 1'b0; clocks(2);
        chk("R10 released", dp_pullup_en, 0);

        // R9: per-bit clear leaves other flags
        flag_clr = 4'b0100; clocks(2); flag_clr = '0;
        chk("R9 clear ok bit", irq_flags, 4'b0011);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule